// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Controller

This block is a register-mapped controller sitting in front of a small array of one-time-programmable fuse words. The array is modelled as 32-bit words held in flops. A plain bus slave exposes four things: a configuration register, a sticky fault register with a write-one-to-clear companion, a key register and a supply register. It also exposes a window with one word per fuse block. Programming a word can only set bits. Clearing a bit is never possible. A word that has been sealed can never change again.

Software prepares a program pass in three steps. It loads the key value 0x8810. It switches on both program supplies. It sets the program-enable bit. Each write into the window then becomes a program pulse. Several options change what a pulse does:
- A lock-write mode seals a block instead of programming it.
- A verify mode reports a readback mismatch.
- A doubled-storage mode also writes a backup copy. Reads then combine the two copies.

A failed operation never stalls or errors the bus. Instead it leaves a sticky fault bit behind, which software polls and clears.

Reset clears every register but keeps the fuse contents and the lock bits, which stand in for non-volatile state. Read data appears one cycle after the read strobe.

Top module: `fuse_ctrl`

## Requirements
- R1: After reset, the configuration, supply, key and fault registers all read 0. A later reset leaves fuse word contents and lock bits exactly as they were.
- R2: Register map and read behaviour:
  - Offsets: configuration at 0x20, fault at 0x24, fault-clear at 0x28, key at 0x2C, supply at 0x54.
  - Configuration bits: bit0 read power, bit1 verify, bit2 double storage, bit3 margin read, bit4 lock-write. It reads back the written low 5 bits.
  - Supply bits: bit0 supply A, bit1 supply B, bit2 program enable. It reads back the written low 3 bits.
  - The key register holds all 32 bits.
  - Unmapped offsets, and the fault register's write path, have no effect. Unmapped offsets read 0.
  - `bus_rdata` updates one cycle after `bus_re`. If `bus_we` and `bus_re` are high together, the write is performed and the read is dropped.
- R3: Fuse word N sits at byte address 0x1000 + 4*N. A window write programs only when three conditions hold: the key equals 0x8810, supply A and supply B are both set, and program enable is set. Failures are checked in order. A wrong key sets only fault bit0. Otherwise a missing supply or program enable sets only fault bit1. In both cases the array is unchanged.
- R4: A successful program ORs the write data into the stored word, so stored bits are never cleared.
- R5: A qualified window write issued with lock-write set seals that word and ignores its data. Any later program of a sealed word sets fault bit2 and leaves it unchanged. Seals are permanent.
- R6: With verify set, a program whose resulting word differs from the requested data sets fault bit3. The program still takes effect.
- R7: With double storage set, a program also ORs the data into a backup copy. A read with double storage set returns the OR of the primary and backup copies.
- R8: A read of an in-range window word with read power clear returns 0 and sets fault bit4.
- R9: A window access to index 96 or above sets fault bit5, changes no word, and a read of it returns 0.
- R10: Fault bits are sticky across 14 bits. Writing ones to 0x28 clears the matching bits and leaves the others set. 0x28 reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | 13 | Byte address of the access |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_re` |

## Verification
Every wrong internal state in this block surfaces as a wrong word or a wrong fault bit, one cycle after the bus access that exposes it. Different faults show up in different places:
- A fault-priority slip shows as the wrong fault bit on the next read of 0x24.
- A bad write-enable path shows as a fuse word that differs from the arithmetic pattern on readback.
- A lost seal shows as a sealed word that changes, or as a missing bit2.

The bench therefore sweeps every word of the array with a computed pattern. It reads the fault register after each stimulus class, and then repeats reads across a reset to expose anything that reset should not have touched.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

  localparam int FLT_W = 14;
  localparam int CFG_W = 5;
  localparam int SUP_W = 3;

  // register offsets inside the control page
  localparam int OFS_CFG  = 'h20;
  localparam int OFS_FLT  = 'h24;
  localparam int OFS_FCLR = 'h28;
  localparam int OFS_KEY  = 'h2C;
  localparam int OFS_SUP  = 'h54;

  localparam logic [31:0] PROG_KEY = 32'h0000_8810;

  // fault bit positions
  localparam int F_KEY    = 0;
  localparam int F_SUPPLY = 1;
  localparam int F_SEALED = 2;
  localparam int F_VERIFY = 3;
  localparam int F_NOPWR  = 4;
  localparam int F_RANGE  = 5;

  typedef struct packed {
    logic lockwr;   // bit4
    logic margin;   // bit3
    logic dbl;      // bit2
    logic verify;   // bit1
    logic rdpwr;    // bit0
  } cfg_t;

  typedef struct packed {
    logic pgen;     // bit2
    logic supb;     // bit1
    logic supa;     // bit0
  } sup_t;

endpackage

// File: rtl/fuse_csr.sv
module fuse_csr
  import fuse_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cfg,
  input  logic              wr_clr,
  input  logic              wr_key,
  input  logic              wr_sup,
  input  logic [DATA_W-1:0] wdata,
  input  logic [FLT_W-1:0]  flt_set,
  output cfg_t              cfg_q,
  output sup_t              sup_q,
  output logic [DATA_W-1:0] key_q,
  output logic [FLT_W-1:0]  flt_q
);

  logic [FLT_W-1:0] clr_mask;
  logic [FLT_W-1:0] flt_d;

  always_comb begin
    clr_mask = wr_clr ? wdata[FLT_W-1:0] : '0;
    flt_d    = (flt_q & ~clr_mask) | flt_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      sup_q <= '0;
      key_q <= '0;
      flt_q <= '0;
    end else begin
      if (wr_cfg) cfg_q <= cfg_t'(wdata[CFG_W-1:0]);
      if (wr_sup) sup_q <= sup_t'(wdata[SUP_W-1:0]);
      if (wr_key) key_q <= wdata;
      flt_q <= flt_d;
    end
  end

  // a fault bit only falls through an explicit clear write
  p_flt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    &(flt_q | ~$past(flt_q) | $past(clr_mask)));

endmodule

// File: rtl/fuse_store.sv
module fuse_store
  import fuse_pkg::*;
#(
  parameter int WORDS      = 96,
  parameter int DATA_W     = 32,
  parameter bit HAS_BACKUP = 1'b1,
  localparam int IDX_W     = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_req,
  input  logic              rd_req,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              key_ok,
  input  logic              sup_ok,
  input  logic              lock_mode,
  input  logic              verify_en,
  input  logic              dbl_en,
  input  logic              rd_pwr,
  output logic [DATA_W-1:0] rd_word,
  output logic [FLT_W-1:0]  flt_set
);

  logic [DATA_W-1:0] prim_q [WORDS];
  logic              lock_q [WORDS];
  logic [DATA_W-1:0] cur_word;
  logic [DATA_W-1:0] bak_word;
  logic              prog_fire;
  logic              lock_fire;

  assign cur_word = prim_q[idx];

  // fault priority: key, supply, seal; then seal or program
  always_comb begin
    prog_fire = 1'b0;
    lock_fire = 1'b0;
    flt_set   = '0;
    if (prog_req) begin
      if (!key_ok)             flt_set[F_KEY]    = 1'b1;
      else if (!sup_ok)        flt_set[F_SUPPLY] = 1'b1;
      else if (lock_q[idx])    flt_set[F_SEALED] = 1'b1;
      else if (lock_mode)      lock_fire         = 1'b1;
      else begin
        prog_fire = 1'b1;
        if (verify_en && ((cur_word | wdata) != wdata)) flt_set[F_VERIFY] = 1'b1;
      end
    end
    if (rd_req && !rd_pwr) flt_set[F_NOPWR] = 1'b1;
  end

  // fuse words and seals carry no reset: they model non-volatile state
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic hit;
    assign hit = (idx == IDX_W'(w));
    always_ff @(posedge clk) begin
      if (prog_fire && hit) prim_q[w] <= prim_q[w] | wdata;
      if (lock_fire && hit) lock_q[w] <= 1'b1;
    end

    p_bits_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (prim_q[w] & $past(prim_q[w])) == $past(prim_q[w]));
    p_seal_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(lock_q[w]) |-> lock_q[w]);
    p_sealed_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(lock_q[w]) |-> $stable(prim_q[w]));
  end

  if (HAS_BACKUP) begin : g_bak
    logic [DATA_W-1:0] bak_q [WORDS];
    for (genvar w = 0; w < WORDS; w++) begin : g_bw
      always_ff @(posedge clk) begin
        if (prog_fire && dbl_en && idx == IDX_W'(w)) bak_q[w] <= bak_q[w] | wdata;
      end
    end
    assign bak_word = dbl_en ? bak_q[idx] : '0;
  end else begin : g_nobak
    assign bak_word = '0;
  end

  assign rd_word = cur_word | bak_word;

endmodule

// File: rtl/fuse_ctrl.sv
module fuse_ctrl
  import fuse_pkg::*;
#(
  parameter int WORDS      = 96,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 13,
  parameter bit HAS_BACKUP = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);

  localparam int IDX_W = $clog2(WORDS);
  localparam int WIN_W = ADDR_W - 3;

  cfg_t              cfg_q;
  sup_t              sup_q;
  logic [DATA_W-1:0] key_q;
  logic [FLT_W-1:0]  flt_q;
  logic [FLT_W-1:0]  store_flt;
  logic [FLT_W-1:0]  flt_set;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] rdata_d;
  logic [WIN_W-1:0]  wofs;
  logic              win, in_rng, rd_en;
  logic              hit_cfg, hit_flt, hit_clr, hit_key, hit_sup;

  // address decode
  always_comb begin
    win     = bus_addr[ADDR_W-1];
    wofs    = bus_addr[ADDR_W-2:2];
    in_rng  = win && (wofs < WIN_W'(WORDS));
    rd_en   = bus_re && !bus_we;
    hit_cfg = (bus_addr == ADDR_W'(OFS_CFG));
    hit_flt = (bus_addr == ADDR_W'(OFS_FLT));
    hit_clr = (bus_addr == ADDR_W'(OFS_FCLR));
    hit_key = (bus_addr == ADDR_W'(OFS_KEY));
    hit_sup = (bus_addr == ADDR_W'(OFS_SUP));
  end

  fuse_csr #(.DATA_W(DATA_W)) u_csr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_cfg  (bus_we && hit_cfg),
    .wr_clr  (bus_we && hit_clr),
    .wr_key  (bus_we && hit_key),
    .wr_sup  (bus_we && hit_sup),
    .wdata   (bus_wdata),
    .flt_set (flt_set),
    .cfg_q   (cfg_q),
    .sup_q   (sup_q),
    .key_q   (key_q),
    .flt_q   (flt_q)
  );

  fuse_store #(.WORDS(WORDS), .DATA_W(DATA_W), .HAS_BACKUP(HAS_BACKUP)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_req  (bus_we && in_rng),
    .rd_req    (rd_en && in_rng),
    .idx       (wofs[IDX_W-1:0]),
    .wdata     (bus_wdata),
    .key_ok    (key_q == PROG_KEY),
    .sup_ok    (sup_q.supa && sup_q.supb && sup_q.pgen),
    .lock_mode (cfg_q.lockwr),
    .verify_en (cfg_q.verify),
    .dbl_en    (cfg_q.dbl),
    .rd_pwr    (cfg_q.rdpwr),
    .rd_word   (rd_word),
    .flt_set   (store_flt)
  );

  always_comb begin
    flt_set = store_flt;
    if ((bus_we || rd_en) && win && !in_rng) flt_set[F_RANGE] = 1'b1;
  end

  // read mux, registered below
  always_comb begin
    rdata_d = '0;
    if (in_rng)       rdata_d = cfg_q.rdpwr ? rd_word : '0;
    else if (hit_cfg) rdata_d = DATA_W'(cfg_q);
    else if (hit_flt) rdata_d = DATA_W'(flt_q);
    else if (hit_key) rdata_d = key_q;
    else if (hit_sup) rdata_d = DATA_W'(sup_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rdata_d;
  end

  p_bad_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && in_rng && key_q != PROG_KEY) |=> flt_q[F_KEY]);
  p_nopwr_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && in_rng && !cfg_q.rdpwr) |=> (bus_rdata == '0 && flt_q[F_NOPWR]));
  p_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_we || bus_re) && win && !in_rng) |=> flt_q[F_RANGE]);
  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(bus_rdata));

endmodule

// File: tb/fuse_ctrl_tb.sv
`timescale 1ns/1ps
module fuse_ctrl_tb;

  localparam int WORDS = 96;
  localparam logic [12:0] A_CFG  = 13'h020;
  localparam logic [12:0] A_FLT  = 13'h024;
  localparam logic [12:0] A_FCLR = 13'h028;
  localparam logic [12:0] A_KEY  = 13'h02C;
  localparam logic [12:0] A_SUP  = 13'h054;
  localparam logic [31:0] KEY    = 32'h8810;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] addr = '0;
  logic        we = 1'b0;
  logic        re = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] expw [WORDS];

  always #4 clk = ~clk;

  fuse_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
    .bus_re(re), .bus_wdata(wdata), .bus_rdata(rdata)
  );

  function automatic logic [12:0] wa(input int i);
    return 13'h1000 + 13'(4 * i);
  endfunction

  function automatic logic [31:0] pat(input int i);
    return (32'(i) * 32'h0103_0507) ^ 32'h5A00_0000;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [12:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; re = 1'b1;
    @(negedge clk); re = 1'b0; v = rdata;
  endtask

  task automatic chk_rd(input string tag, input logic [12:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic clr_all();
    wr(A_FCLR, 32'h3FFF);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    for (int i = 0; i < WORDS; i++) expw[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    chk_rd("R1 cfg", A_CFG, 0);
    chk_rd("R1 sup", A_SUP, 0);
    chk_rd("R1 key", A_KEY, 0);
    chk_rd("R1 flt", A_FLT, 0);

    // R2 map, masks, unmapped, read-only fault, write priority
    wr(A_CFG, 32'hFFFF_FFFF); chk_rd("R2 cfg mask", A_CFG, 32'h1F);
    wr(A_SUP, 32'hFFFF_FFFF); chk_rd("R2 sup mask", A_SUP, 32'h7);
    wr(A_KEY, 32'h1234_5678); chk_rd("R2 key", A_KEY, 32'h1234_5678);
    chk_rd("R2 unmapped", 13'h030, 0);
    wr(A_FLT, 32'hFFFF); chk_rd("R2 flt ro", A_FLT, 0);
    chk_rd("R2 clr reads 0 R10", A_FCLR, 0);
    rd(A_KEY, v);
    @(negedge clk); addr = A_KEY; wdata = 32'hCAFE_0001; we = 1'b1; re = 1'b1;
    @(negedge clk); we = 1'b0; re = 1'b0;
    chk("R2 read dropped", rdata, 32'h1234_5678);
    chk_rd("R2 write taken", A_KEY, 32'hCAFE_0001);
    wr(A_CFG, 0); wr(A_SUP, 0); wr(A_KEY, 0);

    // R8 read without power
    chk_rd("R8 data", wa(0), 0);
    chk_rd("R8 flag", A_FLT, 32'h10);
    clr_all();
    chk_rd("R10 cleared", A_FLT, 0);

    // R3 qualification chain
    wr(A_SUP, 7); wr(wa(0), 32'hFF);
    chk_rd("R3 bad key", A_FLT, 32'h01); clr_all();
    wr(A_KEY, KEY); wr(A_SUP, 3); wr(wa(0), 32'hFF);
    chk_rd("R3 no pgen", A_FLT, 32'h02); clr_all();
    wr(A_SUP, 5); wr(wa(0), 32'hFF);
    chk_rd("R3 one supply", A_FLT, 32'h02); clr_all();
    wr(A_CFG, 1);
    chk_rd("R3 word unchanged", wa(0), 0);

    // R3 R4 full sweep
    wr(A_SUP, 7);
    for (int i = 0; i < WORDS; i++) begin
      wr(wa(i), pat(i));
      expw[i] = pat(i);
    end
    chk_rd("R3 sweep flt", A_FLT, 0);
    for (int i = 0; i < WORDS; i++) chk_rd("R3 sweep word", wa(i), expw[i]);

    // R4 OR accumulation
    wr(wa(7), 32'h0000_F00F); expw[7] |= 32'h0000_F00F;
    chk_rd("R4 or", wa(7), expw[7]);

    // R6 verify
    wr(A_CFG, 32'h3);
    wr(wa(8), expw[8]);
    chk_rd("R6 match", A_FLT, 0);
    wr(wa(9), 32'h1); expw[9] |= 32'h1;
    chk_rd("R6 mismatch", A_FLT, 32'h08);
    chk_rd("R6 applied", wa(9), expw[9]);
    clr_all();

    // R5 sealing
    wr(A_CFG, 32'h11);
    wr(wa(12), 32'hFFFF_FFFF);
    chk_rd("R5 seal no flt", A_FLT, 0);
    chk_rd("R5 data ignored", wa(12), expw[12]);
    wr(A_CFG, 1);
    wr(wa(12), 32'h8000_0000);
    chk_rd("R5 sealed flt", A_FLT, 32'h04);
    chk_rd("R5 sealed word", wa(12), expw[12]);
    clr_all();
    wr(wa(13), 32'h8000_0000); expw[13] |= 32'h8000_0000;
    chk_rd("R5 neighbour", wa(13), expw[13]);

    // R9 out of range
    wr(wa(96), 32'hFFFF_FFFF);
    chk_rd("R9 wr flt", A_FLT, 32'h20); clr_all();
    chk_rd("R9 rd data", wa(127), 0);
    chk_rd("R9 rd flt", A_FLT, 32'h20); clr_all();
    chk_rd("R9 word95 kept", wa(95), expw[95]);

    // R7 double storage
    wr(A_CFG, 32'h5);
    wr(wa(20), 32'h00C0_FFEE); expw[20] |= 32'h00C0_FFEE;
    chk_rd("R7 dbl read", wa(20), expw[20]);
    chk_rd("R7 dbl other", wa(21), expw[21]);
    wr(A_CFG, 1);
    chk_rd("R7 single read", wa(20), expw[20]);

    // R10 partial clear
    wr(A_KEY, 0); wr(wa(30), 32'h1);
    wr(A_CFG, 0); chk_rd("R10 rd off", wa(30), 0);
    chk_rd("R10 both set", A_FLT, 32'h11);
    wr(A_FCLR, 32'h1);
    chk_rd("R10 partial", A_FLT, 32'h10);
    clr_all();

    // R1 retention across reset
    do_reset();
    chk_rd("R1 cfg after", A_CFG, 0);
    chk_rd("R1 key after", A_KEY, 0);
    wr(A_CFG, 1);
    chk_rd("R1 kept 7", wa(7), expw[7]);
    chk_rd("R1 kept 30", wa(30), expw[30]);
    wr(A_KEY, KEY); wr(A_SUP, 7);
    wr(wa(12), 32'h1);
    chk_rd("R1 seal kept", A_FLT, 32'h04);
    chk_rd("R1 sealed word", wa(12), expw[12]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule